// File: doc/BRIEF.md
# Parameterized Eight-Operation ALU

This block is a purely combinational arithmetic and logic unit. The operand and result width is set by one parameter. It takes two operands and a 3-bit operation select. It returns a result word and three status flags: carry, overflow and zero.

Four of the eight operations are arithmetic: addition and subtraction, each in an unsigned and a signed form. Three are bitwise logic operations. The last one halves the first operand. The signed and unsigned forms of the same arithmetic give the same result bits and the same carry, but they judge overflow by different rules.

Subtraction is done as the first operand plus the inverted second operand plus one, in a sum one bit wider than the operands. The carry out of the top bit is therefore 1 when no borrow occurs.

There are no registers inside the block. Every output follows the inputs in the same cycle, so the block can sit inside a larger pipeline stage.

Top module: `eight_op_alu`

## Requirements
- R1: Select 000 gives (A + B) mod 2^WIDTH as an unsigned add. The carry flag is bit WIDTH of the full sum, and overflow equals that carry.
- R2: Select 001 gives the same result bits and carry as R1. Overflow is 1 exactly when A and B have equal sign bits and the result's sign bit differs from A's.
- R3: Select 010 gives (A - B) mod 2^WIDTH. The carry is 1 exactly when A >= B as unsigned numbers, that is, when no borrow occurs. Overflow is the inverse of that carry.
- R4: Select 011 gives the same result bits and carry as R3. Overflow is 1 exactly when the sign bits of A and B differ and the result's sign bit differs from A's.
- R5: Select 100 gives A AND B, select 101 gives A OR B, and select 110 gives A XOR B, bit by bit.
- R6: Select 111 gives A shifted right by one position, with 0 entering the top bit. B has no effect on any output under this select.
- R7: For selects 100 through 111, both the carry flag and the overflow flag are 0.
- R8: The zero flag is 1 exactly when every result bit is 0, for every select.
- R9: The same code is correct at any WIDTH of 2 or more, including 4 and 8, and all outputs depend only on the current inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation select |
| res_o | output | WIDTH | Operation result |
| carry_o | output | 1 | Carry out of the top bit (arithmetic selects only) |
| ovf_o | output | 1 | Overflow, judged by the rule of the selected operation |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The checker assumes that the operands and the select are settled, known values whenever they are sampled. It also assumes that WIDTH is at least 2, so that the halving check can compare bit 0 of the result with bit 1 of A.

The stimulus changes the inputs only between sample points, and it leaves one time unit for the combinational paths to settle before any comparison. It drives every bit pattern, never X or Z.

At width 4 the sweep covers every operand pair under every select. At width 8 it covers every value of A against a strided set of B values that includes 0 and the all-ones value. This reaches the sign-boundary and borrow corner cases at both widths.

// File: rtl/eight_op_alu_pkg.sv
`timescale 1ns/1ps
package eight_op_alu_pkg;
  typedef enum logic [2:0] {
    SEL_UADD = 3'b000,
    SEL_SADD = 3'b001,
    SEL_USUB = 3'b010,
    SEL_SSUB = 3'b011,
    SEL_AND  = 3'b100,
    SEL_OR   = 3'b101,
    SEL_XOR  = 3'b110,
    SEL_HALF = 3'b111
  } alu_sel_e;

  typedef enum logic [1:0] {
    LFN_AND  = 2'b00,
    LFN_OR   = 2'b01,
    LFN_XOR  = 2'b10,
    LFN_HALF = 2'b11
  } logic_fn_e;
endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             sgn_ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  // Subtract as a + ~b + 1 so that a carry of 1 means no borrow
  assign b_eff = b ^ {WIDTH{sub}};
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
  assign sum   = wide[MSB:0];
  assign cout  = wide[WIDTH];

  // Two same-signed addends giving a sum of the other sign
  assign sgn_ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
  import eight_op_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_fn_e        fn,
  output logic [WIDTH-1:0] out
);
  always_comb begin
    unique case (fn)
      LFN_AND:  out = a & b;
      LFN_OR:   out = a | b;
      LFN_XOR:  out = a ^ b;
      default:  out = {1'b0, a[WIDTH-1:1]};
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
`timescale 1ns/1ps
module alu_flags #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] result,
  input  logic             arith,
  input  logic             signed_op,
  input  logic             sub,
  input  logic             cout,
  input  logic             sgn_ovf,
  output logic             carry_flag,
  output logic             ovf_flag,
  output logic             zero_flag
);
  logic uns_ovf;

  // Unsigned: a carry on add, or a missing carry (borrow) on subtract
  assign uns_ovf    = cout ^ sub;
  assign carry_flag = arith & cout;
  assign ovf_flag   = arith & (signed_op ? sgn_ovf : uns_ovf);
  assign zero_flag  = ~|result;
endmodule

// File: rtl/eight_op_alu.sv
`timescale 1ns/1ps
module eight_op_alu
  import eight_op_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);
  logic             is_arith;
  logic             is_sub;
  logic             is_signed;
  logic_fn_e        lfn;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic             add_cout;
  logic             add_sovf;

  // Select bit 2 picks the logic group, bit 1 subtract, bit 0 signed rule
  assign is_arith  = ~op_sel[2];
  assign is_sub    = op_sel[1];
  assign is_signed = op_sel[0];
  assign lfn       = logic_fn_e'(op_sel[1:0]);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a       (op_a),
    .b       (op_b),
    .sub     (is_sub),
    .sum     (arith_res),
    .cout    (add_cout),
    .sgn_ovf (add_sovf)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a   (op_a),
    .b   (op_b),
    .fn  (lfn),
    .out (logic_res)
  );

  assign res_o = is_arith ? arith_res : logic_res;

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .result     (res_o),
    .arith      (is_arith),
    .signed_op  (is_signed),
    .sub        (is_sub),
    .cout       (add_cout),
    .sgn_ovf    (add_sovf),
    .carry_flag (carry_o),
    .ovf_flag   (ovf_o),
    .zero_flag  (zero_o)
  );
endmodule

// File: rtl/eight_op_alu_chk.sv
`timescale 1ns/1ps
module eight_op_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] res_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (op_sel == 3'b000) begin
      p_uadd_ovf_r1: assert (ovf_o == carry_o)
        else $error("R1 unsigned add overflow differs from carry");
    end
    if (op_sel == 3'b001) begin
      p_sadd_ovf_r2: assert (ovf_o == ((op_a[MSB] == op_b[MSB]) && (res_o[MSB] != op_a[MSB])))
        else $error("R2 signed add overflow rule broken");
    end
    if (op_sel == 3'b010) begin
      p_usub_ovf_r3: assert (ovf_o == !carry_o)
        else $error("R3 unsigned subtract overflow is not the borrow");
    end
    if (op_sel == 3'b011) begin
      p_ssub_ovf_r4: assert (ovf_o == ((op_a[MSB] != op_b[MSB]) && (res_o[MSB] != op_a[MSB])))
        else $error("R4 signed subtract overflow rule broken");
    end
    if (op_sel == 3'b111) begin
      p_half_shift_r6: assert (!res_o[MSB] && (res_o[0] == op_a[1]))
        else $error("R6 halving did not shift A right with zero fill");
    end
    if (op_sel[2]) begin
      p_no_flags_r7: assert (!carry_o && !ovf_o)
        else $error("R7 carry or overflow raised by a non-arithmetic select");
    end
    p_zero_flag_r8: assert (zero_o == (res_o == '0))
      else $error("R8 zero flag disagrees with result");
  end
endmodule

bind eight_op_alu eight_op_alu_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/eight_op_alu_tb_top.sv
`timescale 1ns/1ps
module eight_op_alu_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int  vectors = 0;
  int  fails   = 0;
  int  cyc     = 0;
  bit  done    = 1'b0;

  logic [7:0] a8, b8, r8;
  logic [2:0] s8;
  logic       c8, v8, z8;
  logic [3:0] a4, b4, r4;
  logic [2:0] s4;
  logic       c4, v4, z4;

  // R9: the same RTL instantiated at two widths
  eight_op_alu #(.WIDTH(8)) dut_i (
    .op_a(a8), .op_b(b8), .op_sel(s8),
    .res_o(r8), .carry_o(c8), .ovf_o(v8), .zero_o(z8)
  );

  eight_op_alu #(.WIDTH(4)) dut_w4_i (
    .op_a(a4), .op_b(b4), .op_sel(s4),
    .res_o(r4), .carry_o(c4), .ovf_o(v4), .zero_o(z4)
  );

  function automatic string res_tag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      7: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check_vec(input int w, input int op, input int a, input int b,
                           input int r, input bit c, input bit v, input bit z);
    int  mask = (1 << w) - 1;
    int  half = 1 << (w - 1);
    int  sa   = (a >= half) ? a - (1 << w) : a;
    int  sb   = (b >= half) ? b - (1 << w) : b;
    int  er   = 0;
    int  wide = 0;
    bit  ec   = 1'b0;
    bit  ev   = 1'b0;
    bit  ez;
    bit  bad  = 1'b0;
    string ftag;
    case (op)
      0: begin wide = a + b; er = wide & mask; ec = wide > mask; ev = ec; end
      1: begin wide = a + b; er = wide & mask; ec = wide > mask;
               wide = sa + sb; ev = (wide >= half) || (wide < -half); end
      2: begin er = (a - b) & mask; ec = (a >= b); ev = !ec; end
      3: begin er = (a - b) & mask; ec = (a >= b);
               wide = sa - sb; ev = (wide >= half) || (wide < -half); end
      4: er = a & b;
      5: er = a | b;
      6: er = a ^ b;
      default: er = a >> 1;
    endcase
    ez = (er == 0);
    ftag = (op < 4) ? res_tag(op) : "R7";
    vectors++;
    if (r != er) begin
      bad = 1'b1;
      $display("FAIL %s w=%0d sel=%0d a=%0d b=%0d result got %0d exp %0d",
               res_tag(op), w, op, a, b, r, er);
    end
    if (c != ec) begin
      bad = 1'b1;
      $display("FAIL %s w=%0d sel=%0d a=%0d b=%0d carry got %0d exp %0d",
               ftag, w, op, a, b, c, ec);
    end
    if (v != ev) begin
      bad = 1'b1;
      $display("FAIL %s w=%0d sel=%0d a=%0d b=%0d overflow got %0d exp %0d",
               ftag, w, op, a, b, v, ev);
    end
    if (z != ez) begin
      bad = 1'b1;
      $display("FAIL R8 w=%0d sel=%0d a=%0d b=%0d zero got %0d exp %0d",
               w, op, a, b, z, ez);
    end
    if (bad) fails++;
  endtask

  initial begin
    a8 = '0; b8 = '0; s8 = '0;
    a4 = '0; b4 = '0; s4 = '0;
    #1;
    // Idle state: all-zero inputs give a zero result with the zero flag (R8)
    check_vec(8, 0, 0, 0, int'(r8), c8, v8, z8);
    check_vec(4, 0, 0, 0, int'(r4), c4, v4, z4);

    // R9 width 4: exhaustive over every select and operand pair
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          s4 = 3'(op); a4 = 4'(a); b4 = 4'(b);
          #1;
          check_vec(4, op, a, b, int'(r4), c4, v4, z4);
        end
      end
    end

    // R9 width 8: every A against strided B, including 0 and 255
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += ((b == 252) ? 3 : 7)) begin
          s8 = 3'(op); a8 = 8'(a); b8 = 8'(b);
          #1;
          check_vec(8, op, a, b, int'(r8), c8, v8, z8);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule